// File: doc/BRIEF.md
# Low-Side Current Sample-and-Hold Sequencer

This block gates a stream of digitized low-side switch current samples onto a monitor word. A new value is accepted only while the low-side switch conducts, and only after two delays have run out. Both delays start when the PWM command enters its low state. The first covers the propagation from the command to the switch node. The second blanks out the ringing of that transition. Outside that window the last accepted value is held, so the monitor word stays still through high-side conduction and the short gaps on either side of it.

The monitor word is offset binary. Zero current is the mid-code, and the all-ones code is reserved as a saturated fault level. An overcurrent or shorted-switch request forces that fault level at once, and no legal measurement can ever produce it. After reset, or while the power-on-ready flag is low, the word reads zero current. It stays there until the first low-side sample is accepted. The defaults (19 propagation cycles, 16 blanking cycles) give about 350 ns in total at 100 MHz, with 160 ns of that spent blanking.

Top module: `ls_isample_seq`

## Requirements
- R1: The PWM command is decoded as 2'b00 = low, 2'b01 = high, and 2'b10 or 2'b11 = both switches off. A sample is accepted only when the window is open, the command decodes as low and `gl_on` is 1.
- R2: While the command is high or off, `mon_code` holds its last value and `smp_upd` is 0.
- R3: A start event is a clock edge at which the command is sampled low after having been any other value on the previous edge. Call that edge 0. The first sample is accepted at edge PROP_CYC+BLANK_CYC+1.
- R4: If the command leaves the low state before the window opens, the pending window is cancelled. The next start event restarts the full count.
- R5: Each accepted sample updates `mon_code` and drives `smp_upd` to 1 for the cycle that follows that edge. Samples on consecutive edges give consecutive strobes.
- R6: A sample `cur_smp` (two's complement) becomes the offset code with its top bit inverted. With DW=8, 0x00 maps to 0x80, 0x10 to 0x90 and 0x80 to 0x00.
- R7: The largest positive sample is clamped to all-ones minus one (0x7F maps to 0xFE when DW=8), so a measurement never equals the fault code.
- R8: While `oc_flt` or `sc_flt` is 1, `mon_code` is all-ones in the same cycle and no sample is accepted. When the request drops, the held value shows again.
- R9: When `rst` is 1 or `por_ok` is 0, the held value is set to the zero code (0x80 for DW=8), `smp_upd` is cleared and the window is cancelled. A new start event is needed before any sample is accepted.
- R10: With the command still low and the window open, `gl_on` at 0 suppresses sampling without closing the window. Sampling resumes when `gl_on` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supplies ready; 0 clears the held value and the window |
| pwm_code | input | 2 | Decoded PWM command: 00 low, 01 high, 1x off |
| gl_on | input | 1 | Low-side gate currently on |
| cur_smp | input | DW | Signed low-side current sample |
| oc_flt | input | 1 | Overcurrent fault override request |
| sc_flt | input | 1 | Shorted high-side switch fault override request |
| mon_code | output | DW | Offset-binary monitor word, all-ones on fault |
| smp_upd | output | 1 | One-cycle strobe per accepted sample |

## Verification
The bench builds the block with DW=8, PROP_CYC=3 and BLANK_CYC=2. With these values a full window, a cancelled window and its restart each take only a handful of cycles, so the exact edge of the first update can be checked against R3 after entry to the low state from high, from 2'b10 and from 2'b11. The 8-bit width puts the clamp boundary at 0x7F, the most negative sample at 0x80 and the fault code at 0xFF, all reachable as direct vectors. Power-on-ready loss and reset are applied after real samples, and sampling is then attempted without a fresh start event.

// File: rtl/lsmon_pkg.sv
package lsmon_pkg;

    // Decoded PWM command level
    typedef enum logic [1:0] {
        PWM_LO  = 2'b00,
        PWM_HI  = 2'b01,
        PWM_OFF = 2'b10
    } pwm_lvl_e;

    // Sampling window sequencer state
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_PROP  = 2'd1,
        WIN_BLANK = 2'd2,
        WIN_OPEN  = 2'd3
    } win_st_e;

    // Both 2'b10 and 2'b11 mean "both switches off"
    function automatic pwm_lvl_e decode_pwm(input logic [1:0] code);
        case (code)
            2'b00:   return PWM_LO;
            2'b01:   return PWM_HI;
            default: return PWM_OFF;
        endcase
    endfunction

    // A window starts whenever the command enters the low level
    function automatic logic is_start(input pwm_lvl_e prev, input pwm_lvl_e cur);
        return (cur == PWM_LO) && (prev != PWM_LO);
    endfunction

endpackage

// File: rtl/lsmon_win_timer.sv
module lsmon_win_timer
    import lsmon_pkg::*;
#(
    parameter int PROP_CYC  = 19,
    parameter int BLANK_CYC = 16
) (
    input  logic     clk,
    input  logic     clr,
    input  pwm_lvl_e pwm_lvl,
    output logic     win_open
);
    // Both counts must be at least 1
    localparam int MAX_CYC = (PROP_CYC > BLANK_CYC) ? PROP_CYC : BLANK_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROP_LAST  = CNT_W'(PROP_CYC - 1);
    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYC - 1);

    win_st_e          st_q;
    pwm_lvl_e         prev_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q   <= WIN_IDLE;
            cnt_q  <= '0;
            prev_q <= PWM_LO;
        end else begin
            prev_q <= pwm_lvl;
            case (st_q)
                WIN_IDLE: begin
                    if (is_start(prev_q, pwm_lvl)) begin
                        st_q  <= WIN_PROP;
                        cnt_q <= '0;
                    end
                end
                WIN_PROP: begin
                    if (pwm_lvl != PWM_LO) begin
                        st_q <= WIN_IDLE;
                    end else if (cnt_q == PROP_LAST) begin
                        st_q  <= WIN_BLANK;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                WIN_BLANK: begin
                    if (pwm_lvl != PWM_LO) begin
                        st_q <= WIN_IDLE;
                    end else if (cnt_q == BLANK_LAST) begin
                        st_q  <= WIN_OPEN;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (pwm_lvl != PWM_LO) begin
                        st_q <= WIN_IDLE;
                    end
                end
            endcase
        end
    end

    assign win_open = (st_q == WIN_OPEN);

    // R3: the window can only open after the blanking stage
    a_r3_open_after_blank: assert property (@(posedge clk) disable iff (clr)
        (st_q != WIN_BLANK && st_q != WIN_OPEN) |=> (st_q != WIN_OPEN));

    // R3: the counter stays inside the current stage length
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (clr)
        (st_q == WIN_PROP) |-> (cnt_q <= PROP_LAST));

    // R4: leaving the low level always drops the window
    a_r4_cancel_idle: assert property (@(posedge clk) disable iff (clr)
        (pwm_lvl != PWM_LO) |=> (st_q == WIN_IDLE));

endmodule

// File: rtl/lsmon_code_conv.sv
module lsmon_code_conv #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] smp_i,
    output logic [DW-1:0] code_o
);
    logic [DW-1:0] raw;

    always_comb begin
        // Two's complement to offset binary: invert the sign bit
        raw = {~smp_i[DW-1], smp_i[DW-2:0]};
        // All-ones is reserved for the fault level: clear the LSB
        code_o = (&raw) ? {raw[DW-1:1], 1'b0} : raw;
    end

endmodule

// File: rtl/lsmon_hold.sv
module lsmon_hold #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          take,
    input  logic [DW-1:0] code_i,
    output logic [DW-1:0] held_o,
    output logic          upd_o
);
    localparam logic [DW-1:0] ZERO_CODE = {1'b1, {(DW-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (clr) begin
            held_o <= ZERO_CODE;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= take;
            if (take) begin
                held_o <= code_i;
            end
        end
    end

    // R7: an accepted measurement never equals the fault code
    a_r7_no_fault_code: assert property (@(posedge clk) disable iff (clr)
        upd_o |-> (held_o != '1));

    // R5: the strobe marks the cycle that carries the newly taken code
    a_r5_strobe_carries_code: assert property (@(posedge clk) disable iff (clr)
        upd_o |-> (held_o == $past(code_i)));

endmodule

// File: rtl/ls_isample_seq.sv
module ls_isample_seq
    import lsmon_pkg::*;
#(
    parameter int DW        = 12,
    parameter int PROP_CYC  = 19,
    parameter int BLANK_CYC = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          por_ok,
    input  logic [1:0]    pwm_code,
    input  logic          gl_on,
    input  logic [DW-1:0] cur_smp,
    input  logic          oc_flt,
    input  logic          sc_flt,
    output logic [DW-1:0] mon_code,
    output logic          smp_upd
);
    localparam logic [DW-1:0] FAULT_CODE = '1;

    pwm_lvl_e      lvl;
    logic          clr;
    logic          flt;
    logic          win_open;
    logic          take;
    logic [DW-1:0] conv_code;
    logic [DW-1:0] held;

    assign lvl  = decode_pwm(pwm_code);
    assign clr  = rst | ~por_ok;
    assign flt  = oc_flt | sc_flt;
    assign take = win_open & (lvl == PWM_LO) & gl_on & ~flt;

    lsmon_win_timer #(
        .PROP_CYC (PROP_CYC),
        .BLANK_CYC(BLANK_CYC)
    ) u_timer (
        .clk     (clk),
        .clr     (clr),
        .pwm_lvl (lvl),
        .win_open(win_open)
    );

    lsmon_code_conv #(
        .DW(DW)
    ) u_conv (
        .smp_i (cur_smp),
        .code_o(conv_code)
    );

    lsmon_hold #(
        .DW(DW)
    ) u_hold (
        .clk   (clk),
        .clr   (clr),
        .take  (take),
        .code_i(conv_code),
        .held_o(held),
        .upd_o (smp_upd)
    );

    // The fault level overrides the held value without delay
    assign mon_code = flt ? FAULT_CODE : held;

    // R1: no update follows an edge with the low gate off
    a_r1_gate_off_no_update: assert property (@(posedge clk) disable iff (clr)
        !gl_on |=> !smp_upd);

    // R2: high or off command: no strobe and the held value is unchanged
    a_r2_hold_outside_low: assert property (@(posedge clk) disable iff (clr)
        (lvl != PWM_LO) |=> (!smp_upd && $stable(held)));

    // R8: a fault request blocks the next update
    a_r8_fault_blocks_update: assert property (@(posedge clk) disable iff (clr)
        flt |=> !smp_upd);

endmodule

// File: tb/test_ls_isample_seq.sv
module test_ls_isample_seq;

    localparam int DW = 8;
    localparam int PC = 3;
    localparam int BC = 2;
    localparam int NV = 41;

    logic          clk    = 1'b0;
    logic          rst    = 1'b1;
    logic          por_ok = 1'b1;
    logic [1:0]    pwm    = 2'b01;
    logic          gl     = 1'b0;
    logic [DW-1:0] cur    = '0;
    logic          oc     = 1'b0;
    logic          sc     = 1'b0;
    logic [DW-1:0] mon;
    logic          upd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // rq: requirement number printed with a failure
    typedef struct packed {
        logic [3:0] rq;
        logic [1:0] pwm;
        logic       gl;
        logic [7:0] cur;
        logic       oc;
        logic       sc;
        logic [7:0] mon;
        logic       upd;
    } vec_t;

    // One entry per clock: drive inputs, then expect outputs after the edge
    localparam vec_t VEC [0:NV-1] = '{
        '{4'd9,  2'b01, 1'b0, 8'h10, 1'b0, 1'b0, 8'h80, 1'b0}, // 0  R9 zero before any sample
        '{4'd3,  2'b00, 1'b1, 8'h10, 1'b0, 1'b0, 8'h80, 1'b0}, // 1  R3 edge 0
        '{4'd3,  2'b00, 1'b1, 8'h10, 1'b0, 1'b0, 8'h80, 1'b0}, // 2  R3
        '{4'd3,  2'b00, 1'b1, 8'h10, 1'b0, 1'b0, 8'h80, 1'b0}, // 3  R3
        '{4'd3,  2'b00, 1'b1, 8'h10, 1'b0, 1'b0, 8'h80, 1'b0}, // 4  R3
        '{4'd3,  2'b00, 1'b1, 8'h10, 1'b0, 1'b0, 8'h80, 1'b0}, // 5  R3
        '{4'd3,  2'b00, 1'b1, 8'h10, 1'b0, 1'b0, 8'h80, 1'b0}, // 6  R3 edge 5
        '{4'd3,  2'b00, 1'b1, 8'h10, 1'b0, 1'b0, 8'h90, 1'b1}, // 7  R3 R6 first sample at edge 6
        '{4'd5,  2'b00, 1'b1, 8'h05, 1'b0, 1'b0, 8'h85, 1'b1}, // 8  R5 back-to-back strobe
        '{4'd10, 2'b00, 1'b0, 8'h20, 1'b0, 1'b0, 8'h85, 1'b0}, // 9  R10 gate off pauses
        '{4'd10, 2'b00, 1'b1, 8'hF0, 1'b0, 1'b0, 8'h70, 1'b1}, // 10 R10 window still open
        '{4'd2,  2'b01, 1'b0, 8'h33, 1'b0, 1'b0, 8'h70, 1'b0}, // 11 R2 hold during high
        '{4'd2,  2'b01, 1'b0, 8'h44, 1'b0, 1'b0, 8'h70, 1'b0}, // 12 R2
        '{4'd4,  2'b00, 1'b1, 8'h7F, 1'b0, 1'b0, 8'h70, 1'b0}, // 13 R4 start
        '{4'd4,  2'b00, 1'b1, 8'h7F, 1'b0, 1'b0, 8'h70, 1'b0}, // 14 R4
        '{4'd4,  2'b01, 1'b0, 8'h7F, 1'b0, 1'b0, 8'h70, 1'b0}, // 15 R4 early high cancels
        '{4'd4,  2'b00, 1'b1, 8'h7F, 1'b0, 1'b0, 8'h70, 1'b0}, // 16 R4 restart edge 0
        '{4'd4,  2'b00, 1'b1, 8'h7F, 1'b0, 1'b0, 8'h70, 1'b0}, // 17 R4
        '{4'd4,  2'b00, 1'b1, 8'h7F, 1'b0, 1'b0, 8'h70, 1'b0}, // 18 R4
        '{4'd4,  2'b00, 1'b1, 8'h7F, 1'b0, 1'b0, 8'h70, 1'b0}, // 19 R4
        '{4'd4,  2'b00, 1'b1, 8'h7F, 1'b0, 1'b0, 8'h70, 1'b0}, // 20 R4
        '{4'd4,  2'b00, 1'b1, 8'h7F, 1'b0, 1'b0, 8'h70, 1'b0}, // 21 R4 edge 5
        '{4'd7,  2'b00, 1'b1, 8'h7F, 1'b0, 1'b0, 8'hFE, 1'b1}, // 22 R7 clamp
        '{4'd8,  2'b00, 1'b1, 8'h80, 1'b1, 1'b0, 8'hFF, 1'b0}, // 23 R8 overcurrent
        '{4'd8,  2'b00, 1'b1, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b0}, // 24 R8 shorted switch
        '{4'd8,  2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 8'hFE, 1'b0}, // 25 R8 held value back
        '{4'd1,  2'b00, 1'b1, 8'h80, 1'b0, 1'b0, 8'hFE, 1'b0}, // 26 R1 start from off
        '{4'd1,  2'b00, 1'b1, 8'h80, 1'b0, 1'b0, 8'hFE, 1'b0}, // 27 R1
        '{4'd1,  2'b00, 1'b1, 8'h80, 1'b0, 1'b0, 8'hFE, 1'b0}, // 28 R1
        '{4'd1,  2'b00, 1'b1, 8'h80, 1'b0, 1'b0, 8'hFE, 1'b0}, // 29 R1
        '{4'd1,  2'b00, 1'b1, 8'h80, 1'b0, 1'b0, 8'hFE, 1'b0}, // 30 R1
        '{4'd1,  2'b00, 1'b1, 8'h80, 1'b0, 1'b0, 8'hFE, 1'b0}, // 31 R1
        '{4'd6,  2'b00, 1'b1, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1}, // 32 R6 most negative
        '{4'd1,  2'b11, 1'b1, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0}, // 33 R1 code 11 is off
        '{4'd1,  2'b00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // 34 R1 start from 11
        '{4'd1,  2'b00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // 35 R1
        '{4'd1,  2'b00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // 36 R1
        '{4'd1,  2'b00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // 37 R1
        '{4'd1,  2'b00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // 38 R1
        '{4'd1,  2'b00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // 39 R1
        '{4'd6,  2'b00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h80, 1'b1}  // 40 R6 zero maps to mid-code
    };

    ls_isample_seq #(
        .DW       (DW),
        .PROP_CYC (PC),
        .BLANK_CYC(BC)
    ) i_ls_isample_seq (
        .clk     (clk),
        .rst     (rst),
        .por_ok  (por_ok),
        .pwm_code(pwm),
        .gl_on   (gl),
        .cur_smp (cur),
        .oc_flt  (oc),
        .sc_flt  (sc),
        .mon_code(mon),
        .smp_upd (upd)
    );

    always #5 clk = ~clk;

    task automatic check(input int rq, input logic [7:0] exp_mon, input logic exp_upd);
        total++;
        if (mon !== exp_mon || upd !== exp_upd) begin
            bad++;
            $display("FAIL R%0d: mon=%h upd=%b expected mon=%h upd=%b",
                     rq, mon, upd, exp_mon, exp_upd);
        end
    endtask

    // Wait for the next rising edge, then sample away from it
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        step();
        check(9, 8'h80, 1'b0); // R9 reset state
        step();
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            pwm = VEC[i].pwm;
            gl  = VEC[i].gl;
            cur = VEC[i].cur;
            oc  = VEC[i].oc;
            sc  = VEC[i].sc;
            step();
            check(int'(VEC[i].rq), VEC[i].mon, VEC[i].upd);
            @(negedge clk);
        end

        // R5: one more sample from the still-open window
        pwm = 2'b00; gl = 1'b1; cur = 8'h30;
        step();
        check(5, 8'hB0, 1'b1);

        // R9: losing power-on-ready returns the zero code
        @(negedge clk);
        por_ok = 1'b0;
        step();
        check(9, 8'h80, 1'b0);

        // R8: override applies even while not ready
        @(negedge clk);
        oc = 1'b1;
        #1;
        check(8, 8'hFF, 1'b0);
        oc = 1'b0;

        // R9: ready again with PWM low throughout: no start event, no sample
        @(negedge clk);
        por_ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step();
            check(9, 8'h80, 1'b0);
            @(negedge clk);
        end

        // R3: fresh high-to-low transition, exact first-update edge
        pwm = 2'b01; gl = 1'b0;
        step();
        check(2, 8'h80, 1'b0);
        @(negedge clk);
        pwm = 2'b00; gl = 1'b1;
        for (int k = 0; k < PC + BC + 1; k++) begin
            step();
            check(3, 8'h80, 1'b0);
            @(negedge clk);
        end
        step();
        check(3, 8'hB0, 1'b1);

        // R9: synchronous reset clears the held sample
        @(negedge clk);
        rst = 1'b1;
        step();
        check(9, 8'h80, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        step();
        check(9, 8'h80, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule